// File: doc/BRIEF.md
# Fixed-point temperature to BCD formatter

This block takes a signed 16-bit temperature word and turns it into eight decimal digits for a display driver. The word holds whole degrees in its upper nine bits and sixteenths of a degree in the next four bits. The three lowest bits carry nothing used. The whole-degree field becomes four BCD digits. The sixteenths field indexes a small table of ten-thousandths, and the table value becomes four more BCD digits. Together they give an exact reading such as 0025.0625.

A one-cycle `convert_i` strobe samples the word. The digit register loads on that clock edge and then holds. `valid_o` marks the cycle in which the new digits first appear. A reading with its sign bit set is shown as all zeros. There is no minus sign. A constant decimal-point mask lights the point after the fourth digit, so the point sits between the whole and the fractional digits. Segment decoding and digit scanning are left to the display driver.

Top module: `temp_bcd_fmt`

## Requirements
- R1: The whole-degree field `temp_i[15:7]`, read as unsigned, appears as four BCD digits in `digits_o[31:16]`. The most significant digit is in `digits_o[31:28]`.
- R2: The sixteenths field `temp_i[6:3]` = k appears as the four BCD digits of k*625 (ten-thousandths of a degree) in `digits_o[15:0]`. The most significant digit is in `digits_o[15:12]`.
- R3: Bits `temp_i[2:0]` have no effect on `digits_o`.
- R4: When `temp_i[15]` is 1 at a convert, all 32 bits of `digits_o` load as zero.
- R5: `digits_o` loads on the rising edge at which `convert_i` is 1. On any edge with `convert_i` at 0 it keeps its value, whatever `temp_i` does.
- R6: `valid_o` is 1 during exactly the cycle that follows each edge that samples `convert_i` = 1. It is 0 otherwise.
- R7: `dp_mask_o` is always 8'b0001_0000. Bit 4 is set and all other bits are clear.
- R8: While `rst_n` is 0, `digits_o` is all zeros and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| convert_i | input | 1 | One-cycle request to capture and convert `temp_i` |
| temp_i | input | 16 | Signed fixed-point temperature word |
| digits_o | output | 32 | Eight BCD digits: four whole, four fractional, most significant first |
| dp_mask_o | output | 8 | Decimal-point enable per digit, constant |
| valid_o | output | 1 | High for one cycle when new digits are present |

## Verification
Every result depends on a single register stage. The digits and `valid_o` for a strobe sampled at edge N are due right after edge N. The bench raises inputs on the falling edge and reads outputs on the next falling edge, which is half a period after the loading edge. One falling edge later it checks that `valid_o` has dropped and that the digits did not move, even though `temp_i` was changed to a new value. Back-to-back strobes are checked edge by edge. The decimal-point mask is compared at every sample point, because it has no latency.

// File: rtl/temp_bcd_pkg.sv
// Package: shared constants for the temperature formatter.
// Assumes a 16-bit word: sign at the MSB, a 9-bit whole field, a 4-bit sixteenths field.
package temp_bcd_pkg;
    localparam int WORD_W     = 16;
    localparam int WHOLE_LSB  = 7;
    localparam int WHOLE_W    = WORD_W - WHOLE_LSB;    // 9
    localparam int SIXT_LSB   = 3;
    localparam int SIXT_W     = WHOLE_LSB - SIXT_LSB;  // 4
    localparam int SIXT_STEP  = 625;                   // 1/16 in ten-thousandths
    localparam int SIXT_MAXV  = ((1 << SIXT_W) - 1) * SIXT_STEP;
    localparam int SIXT_VAL_W = $clog2(SIXT_MAXV + 1);
    localparam int WHOLE_DIG  = 4;
    localparam int FRAC_DIG   = 4;
    localparam int DIG_W      = 4 * (WHOLE_DIG + FRAC_DIG);
    localparam logic [7:0] DP_MASK = 8'b0001_0000;
endpackage

// File: rtl/temp_frac_rom.sv
// Module: lookup from a sixteenths index to its value in ten-thousandths.
// Assumes STEP * (2**IDX_W - 1) fits in VAL_W bits. The table is computed, not written out.
module temp_frac_rom #(
    parameter int IDX_W = 4,
    parameter int STEP  = 625,
    parameter int VAL_W = 14
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [VAL_W-1:0] val_o
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [VAL_W-1:0] table_q [ENTRIES];

    // Fill each table entry with its index times the step.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_q[g] = VAL_W'(g * STEP);
    end

    // Read the selected entry.
    assign val_o = table_q[idx_i];
endmodule

// File: rtl/temp_bin2bcd.sv
// Module: combinational binary-to-BCD converter using shift-and-add-3.
// Assumes DIGITS is large enough for 2**IN_W - 1. Larger values would lose their top digits.
module temp_bin2bcd #(
    parameter int IN_W   = 9,
    parameter int DIGITS = 4
) (
    input  logic [IN_W-1:0]     bin_i,
    output logic [DIGITS*4-1:0] bcd_o
);
    localparam int BCD_W = DIGITS * 4;

    // Shift-and-add-3 over every input bit, MSB first.
    function automatic logic [BCD_W-1:0] dabble(input logic [IN_W-1:0] b);
        logic [BCD_W+IN_W-1:0] sh;
        sh = {{BCD_W{1'b0}}, b};
        for (int i = 0; i < IN_W; i++) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (sh[IN_W + 4*d +: 4] >= 4'd5)
                    sh[IN_W + 4*d +: 4] = sh[IN_W + 4*d +: 4] + 4'd3;
            end
            sh = sh << 1;
        end
        return sh[IN_W +: BCD_W];
    endfunction

    // Drive the converted digits.
    assign bcd_o = dabble(bin_i);
endmodule

// File: rtl/temp_bcd_fmt.sv
// Module: registered converter from a signed fixed-point temperature to eight BCD digits.
// Assumes convert_i is a single-cycle strobe. Negative words are shown as zero. Reset is synchronous, active low.
module temp_bcd_fmt
    import temp_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              convert_i,
    input  logic [WORD_W-1:0] temp_i,
    output logic [DIG_W-1:0]  digits_o,
    output logic [7:0]        dp_mask_o,
    output logic              valid_o
);
    logic [WHOLE_W-1:0]    whole_bin;
    logic [SIXT_W-1:0]     sixt_idx;
    logic [SIXT_VAL_W-1:0] sixt_val;
    logic [WHOLE_DIG*4-1:0] whole_bcd;
    logic [FRAC_DIG*4-1:0]  frac_bcd;
    logic                  unused_pad;

    // Split the word into its fields. The low pad bits are deliberately dropped.
    assign whole_bin  = temp_i[WORD_W-1:WHOLE_LSB];
    assign sixt_idx   = temp_i[WHOLE_LSB-1:SIXT_LSB];
    assign unused_pad = ^temp_i[SIXT_LSB-1:0];

    temp_frac_rom #(
        .IDX_W (SIXT_W),
        .STEP  (SIXT_STEP),
        .VAL_W (SIXT_VAL_W)
    ) u_rom (
        .idx_i (sixt_idx),
        .val_o (sixt_val)
    );

    temp_bin2bcd #(
        .IN_W   (WHOLE_W),
        .DIGITS (WHOLE_DIG)
    ) u_whole (
        .bin_i (whole_bin),
        .bcd_o (whole_bcd)
    );

    temp_bin2bcd #(
        .IN_W   (SIXT_VAL_W),
        .DIGITS (FRAC_DIG)
    ) u_frac (
        .bin_i (sixt_val),
        .bcd_o (frac_bcd)
    );

    // Capture the digits on a strobe, clamp negative words to zero, and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= convert_i;
            if (convert_i) begin
                if (temp_i[WORD_W-1])
                    digits_o <= '0;
                else
                    digits_o <= {whole_bcd, frac_bcd};
            end
        end
    end

    // The decimal point is fixed after the fourth digit.
    assign dp_mask_o = DP_MASK;
endmodule

// File: rtl/temp_bcd_fmt_chk.sv
// Checker: timing and format properties of temp_bcd_fmt, attached to it with bind.
// Assumes the same synchronous active-low reset as the design.
module temp_bcd_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        convert_i,
    input logic        temp_msb,
    input logic [31:0] digits_o,
    input logic [7:0]  dp_mask_o,
    input logic        valid_o
);
    // True when every nibble is a decimal digit.
    function automatic logic all_bcd(input logic [31:0] v);
        logic ok;
        ok = 1'b1;
        for (int n = 0; n < 8; n++)
            if (v[4*n +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    AST_VALID_AFTER_CONVERT: assert property (@(posedge clk) disable iff (!rst_n) convert_i |=> valid_o);   // R6
    AST_NO_STRAY_VALID:      assert property (@(posedge clk) disable iff (!rst_n) !convert_i |=> !valid_o); // R6
    AST_DIGITS_HELD:         assert property (@(posedge clk) disable iff (!rst_n) !convert_i |=> $stable(digits_o)); // R5
    AST_NEG_CLAMP:           assert property (@(posedge clk) disable iff (!rst_n) (convert_i && temp_msb) |=> (digits_o == 32'd0)); // R4
    AST_DIGITS_DECIMAL:      assert property (@(posedge clk) disable iff (!rst_n) all_bcd(digits_o));        // R1
    AST_DP_FIXED:            assert property (@(posedge clk) disable iff (!rst_n) dp_mask_o == 8'b0001_0000); // R7
    AST_RESET_CLEARS:        assert property (@(posedge clk) !rst_n |=> (digits_o == 32'd0 && !valid_o)); // R8
endmodule

bind temp_bcd_fmt temp_bcd_fmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .convert_i (convert_i),
    .temp_msb  (temp_i[15]),
    .digits_o  (digits_o),
    .dp_mask_o (dp_mask_o),
    .valid_o   (valid_o)
);

// File: tb/tb_temp_bcd_fmt.sv
module tb_temp_bcd_fmt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        convert_i = 1'b0;
    logic [15:0] temp_i = '0;
    logic [31:0] digits_o;
    logic [7:0]  dp_mask_o;
    logic        valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    temp_bcd_fmt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .convert_i (convert_i),
        .temp_i    (temp_i),
        .digits_o  (digits_o),
        .dp_mask_o (dp_mask_o),
        .valid_o   (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Four decimal digits of v, most significant first.
    function automatic logic [15:0] dec4(input int v);
        return {4'((v/1000)%10), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
    endfunction

    // Expected display digits from the requirements (R1, R2, R3, R4).
    function automatic logic [31:0] expect_digits(input logic [15:0] w);
        if (w[15]) return 32'd0;
        return {dec4(int'(w[15:7])), dec4(int'(w[6:3]) * 625)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe one word, then check load, valid, hold and mask.
    task automatic run_word(input logic [15:0] w);
        logic [31:0] e;
        e = expect_digits(w);
        @(negedge clk);
        convert_i = 1'b1;
        temp_i    = w;
        @(negedge clk);
        convert_i = 1'b0;
        temp_i    = ~w;
        check(w[15] ? "R4" : "R1/R2", digits_o, e);
        check("R6", {31'd0, valid_o}, 32'd1);
        check("R7", {24'd0, dp_mask_o}, 32'h10);
        @(negedge clk);
        check("R5", digits_o, e);
        check("R6", {31'd0, valid_o}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] first;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", digits_o, 32'd0);
        check("R8", {31'd0, valid_o}, 32'd0);
        check("R7", {24'd0, dp_mask_o}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases.
        run_word(16'h0000);
        run_word(16'h0C80);              // 25.0000
        run_word(16'h0C88);              // 25.0625
        run_word(16'h7FF8);              // 255.9375
        run_word(16'h0078);              // 0.9375
        run_word(16'h8000);              // negative, R4
        run_word(16'hFFFF);              // negative, R4
        run_word(16'h0100);              // 2.0000

        // R3: pad bits have no effect.
        run_word(16'h1A50);
        first = digits_o;
        run_word(16'h1A57);
        check("R3", digits_o, first);

        // R5: back-to-back strobes load on each edge.
        @(negedge clk);
        convert_i = 1'b1; temp_i = 16'h0A08;
        @(negedge clk);
        check("R5", digits_o, expect_digits(16'h0A08));
        temp_i = 16'h3210;
        @(negedge clk);
        convert_i = 1'b0; temp_i = 16'h0000;
        check("R5", digits_o, expect_digits(16'h3210));
        check("R6", {31'd0, valid_o}, 32'd1);
        @(negedge clk);
        check("R6", {31'd0, valid_o}, 32'd0);

        // Random words.
        for (int n = 0; n < 200; n++) begin
            run_word(16'($urandom));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule